// File: doc/BRIEF.md
# Floating-Point Sticky Status and Trap Request Unit

This unit holds the floating-point status word of a 32-bit soft processor. The arithmetic datapath reports exception conditions from each operation as a strobe plus four flag bits: invalid operation, divide by zero, overflow and underflow. The unit ORs those flags into sticky status bits. Only a software write clears them. Software reads the word at any time and overwrites it with a move-to-special-register access, which keeps only the low five bits.

When an operation reports at least one flag, the unit decides whether to trap. It raises a one-cycle exception request only when two bits are both set: a build-time capability bit that says floating-point traps exist, and the run-time exception-enable bit of the machine status register. Each request loads a cause register with the floating-point cause code. Compare operations pass on only their invalid flag. The unit does no arithmetic.

Top module: `fpsr_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the status word, `exc_req` and `exc_cause` are all cleared to zero.
- R2: On a strobe (`op_valid`=1), each raised bit of `op_flags` is ORed into the status word. `op_flags[3]` (invalid) maps to status bit 4, `op_flags[2]` (divide by zero) to bit 3, `op_flags[1]` (overflow) to bit 2 and `op_flags[0]` (underflow) to bit 1. A strobe never clears a status bit.
- R3: When `op_is_cmp`=1, only `op_flags[3]` is forwarded. The divide-by-zero, overflow and underflow flags are dropped: they set no status bit and cannot cause a trap.
- R4: When `op_valid`=0, `op_flags` and `op_is_cmp` have no effect on the status word or on `exc_req`.
- R5: A write (`sr_wr_en`=1) stores `sr_wr_data[4:0]` into the status word, including bit 0, which is kept exactly as written. From the next cycle, `sr_rd_data` returns the stored bits, and bits 31:5 always read as zero.
- R6: If a write and a strobe occur in the same cycle, the written value is stored with the forwarded flags ORed on top.
- R7: `exc_req` is high for exactly the one cycle after a strobe whose forwarded flags are non-zero while both `cfg_fp_trap` and `msr_exc_en` are 1. In every other case it stays low. Back-to-back qualifying strobes give back-to-back pulses.
- R8: Each time `exc_req` rises, `exc_cause` is loaded with the cause code (default 6) in the same cycle, and it holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Flag strobe from the arithmetic datapath |
| op_is_cmp | input | 1 | Strobe comes from a compare operation |
| op_flags | input | 4 | {invalid, divide-by-zero, overflow, underflow} |
| cfg_fp_trap | input | 1 | Build-time floating-point trap capability |
| msr_exc_en | input | 1 | Run-time exception enable from machine status |
| sr_wr_en | input | 1 | Software write to the status word |
| sr_wr_data | input | 32 | Write data; only bits 4:0 are kept |
| sr_rd_data | output | 32 | Current status word, zero-extended |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 5 | Exception cause register |

## Verification
The hardest case to reach is a write and a strobe landing on the same edge while trapping is enabled. In that case the stored word, the flag merge and the request pulse must all agree. The stimulus reaches it through deliberate collisions, and then through a long pseudo-random run in which write, strobe, compare and both enables toggle independently. Every cycle is compared against a behavioural model. The compare-only masking is driven with every non-invalid flag raised at once, so that a leak shows both in the status word and in a stray request.

// File: rtl/fpsr_pkg.sv
// Package: shared flag type and status-word bit placement for the FP status unit.
// Assumes the four flags keep the fixed order invalid, div-zero, overflow, underflow.
package fpsr_pkg;
    localparam int N_FLAGS  = 4;
    localparam int FLAG_LSB = 1;   // status bit that holds the underflow flag

    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
    } fp_flags_t;
endpackage

// File: rtl/fpsr_flag_filter.sv
// Module: selects which reported flags reach the status word and trap logic.
// Assumes compare operations may only report invalid; other ops report all four.
module fpsr_flag_filter
    import fpsr_pkg::*;
(
    input  logic      op_valid,
    input  logic      op_is_cmp,
    input  fp_flags_t raw,
    output fp_flags_t fwd,
    output logic      any_fwd
);
    // Gate flags by strobe and mask non-invalid flags on compares.
    always_comb begin
        fwd = '0;
        if (op_valid) begin
            fwd.inv = raw.inv;
            if (!op_is_cmp) begin
                fwd.dz  = raw.dz;
                fwd.ovf = raw.ovf;
                fwd.unf = raw.unf;
            end
        end
        any_fwd = |fwd;
    end
endmodule

// File: rtl/fpsr_sticky_reg.sv
// Module: sticky status word; software write stores low bits, flags OR on top.
// Assumes STAT_W covers the reserved bit plus the four flag bits.
module fpsr_sticky_reg
    import fpsr_pkg::*;
#(
    parameter int STAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_val,
    input  fp_flags_t         fwd,
    output logic [STAT_W-1:0] status
);
    localparam int FLAG_MSB = FLAG_LSB + N_FLAGS - 1;

    logic [STAT_W-1:0]  base;
    logic [STAT_W-1:0]  nxt;
    logic [N_FLAGS-1:0] fvec;

    // Pick the starting value: software write wins over the held word.
    always_comb begin
        fvec = fwd;
        base = wr_en ? wr_val : status;
    end

    // Per-bit merge: flag bits OR in, other bits pass through.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b >= FLAG_LSB && b <= FLAG_MSB) begin : g_flag
            assign nxt[b] = base[b] | fvec[b-FLAG_LSB];
        end else begin : g_plain
            assign nxt[b] = base[b];
        end
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= nxt;
    end

    // R2: without a write, no flag bit ever falls.
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |->
        ((status[FLAG_MSB:FLAG_LSB] & $past(status[FLAG_MSB:FLAG_LSB]))
         == $past(status[FLAG_MSB:FLAG_LSB])));

    // R5: a write with no flags lands exactly as written.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(|fvec)) |-> status == $past(wr_val));
endmodule

// File: rtl/fpsr_trap_ctrl.sv
// Module: registers the exception request and the cause register.
// Assumes both enables are level signals sampled in the strobe cycle.
module fpsr_trap_ctrl #(
    parameter int                  CAUSE_W    = 5,
    parameter logic [CAUSE_W-1:0]  CAUSE_CODE = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_fwd,
    input  logic               cfg_fp_trap,
    input  logic               msr_exc_en,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);
    logic fire;

    // Qualify a flagged strobe by capability and run-time enable.
    always_comb fire = any_fwd && cfg_fp_trap && msr_exc_en;

    // Issue the one-cycle request and load the cause with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req   <= 1'b0;
            exc_cause <= '0;
        end else begin
            exc_req <= fire;
            if (fire) exc_cause <= CAUSE_CODE;
        end
    end

    // R7: a request follows only a qualifying strobe.
    a_r7_req_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(any_fwd && cfg_fp_trap && msr_exc_en));

    // R7: without a new flagged strobe the pulse ends after one cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !any_fwd) |=> !exc_req);

    // R8: a request always carries the cause code.
    a_r8_cause_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_cause == CAUSE_CODE);

    // R8: the cause holds when no request is raised.
    a_r8_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> $stable(exc_cause));
endmodule

// File: rtl/fpsr_unit.sv
// Module: top of the floating-point sticky status and trap request unit.
// Assumes a single clock domain and one flag strobe per cycle at most.
module fpsr_unit
    import fpsr_pkg::*;
#(
    parameter int                 DATA_W     = 32,
    parameter int                 STAT_W     = 5,
    parameter int                 CAUSE_W    = 5,
    parameter logic [CAUSE_W-1:0] CAUSE_CODE = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic               op_is_cmp,
    input  logic [3:0]         op_flags,
    input  logic               cfg_fp_trap,
    input  logic               msr_exc_en,
    input  logic               sr_wr_en,
    input  logic [DATA_W-1:0]  sr_wr_data,
    output logic [DATA_W-1:0]  sr_rd_data,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);
    localparam int PAD_W = DATA_W - STAT_W;

    fp_flags_t         raw;
    fp_flags_t         fwd;
    logic              any_fwd;
    logic [STAT_W-1:0] status;

    // Unpack the raw flag vector into the shared flag type.
    always_comb raw = fp_flags_t'(op_flags);

    fpsr_flag_filter u_filter (
        .op_valid (op_valid),
        .op_is_cmp(op_is_cmp),
        .raw      (raw),
        .fwd      (fwd),
        .any_fwd  (any_fwd)
    );

    fpsr_sticky_reg #(.STAT_W(STAT_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sr_wr_en),
        .wr_val(sr_wr_data[STAT_W-1:0]),
        .fwd   (fwd),
        .status(status)
    );

    fpsr_trap_ctrl #(.CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_fwd    (any_fwd),
        .cfg_fp_trap(cfg_fp_trap),
        .msr_exc_en (msr_exc_en),
        .exc_req    (exc_req),
        .exc_cause  (exc_cause)
    );

    // Zero-extend the status word onto the read port.
    always_comb sr_rd_data = {{PAD_W{1'b0}}, status};

    // R3: a compare without invalid never produces a request.
    a_r3_cmp_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_is_cmp && !op_flags[3]) |-> !exc_req);

    // R4: an idle cycle with no write leaves the word unchanged.
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!op_valid && !sr_wr_en) |-> $stable(sr_rd_data));

    // R2: an invalid flag on any strobe is visible next cycle.
    a_r2_invalid_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_flags[3]) |-> sr_rd_data[4]);
endmodule

// File: tb/fpsr_unit_tb_top.sv
// Bench: drives the unit and compares every cycle with a behavioural model.
module fpsr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_is_cmp = 1'b0;
    logic [3:0]  op_flags = '0;
    logic        cfg_fp_trap = 1'b0, msr_exc_en = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic [31:0] sr_rd_data;
    logic        exc_req;
    logic [4:0]  exc_cause;

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit    done = 0;

    // Model state.
    int m_status = 0, m_req = 0, m_cause = 0;

    always #2.5 clk = ~clk;

    fpsr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
        .op_flags(op_flags), .cfg_fp_trap(cfg_fp_trap), .msr_exc_en(msr_exc_en),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .exc_req(exc_req), .exc_cause(exc_cause)
    );

    // Behavioural model updated on each rising edge from the driven inputs.
    always @(posedge clk) begin
        int f;
        if (!rst_n) begin
            m_status = 0; m_req = 0; m_cause = 0;
        end else begin
            f = 0;
            if (op_valid) f = op_is_cmp ? (op_flags & 4'b1000) : op_flags;
            if (sr_wr_en) m_status = sr_wr_data % 32;
            m_status = m_status | (f * 2);
            m_req = (f != 0 && cfg_fp_trap && msr_exc_en) ? 1 : 0;
            if (m_req == 1) m_cause = 6;
        end
    end

    task automatic chk(string t, longint act, longint exp_v, string what);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp_v);
        end
    endtask

    // Compare all outputs on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(tag, sr_rd_data, m_status, "status");
            chk(tag, exc_req, m_req, "exc_req");
            chk(tag, exc_cause, m_cause, "exc_cause");
        end
    end

    task automatic drive(bit v, bit c, logic [3:0] f, bit w, logic [31:0] wd,
                         bit cfg, bit msr);
        op_valid = v; op_is_cmp = c; op_flags = f; sr_wr_en = w;
        sr_wr_data = wd; cfg_fp_trap = cfg; msr_exc_en = msr;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 4'h0, 0, 32'h0, cfg_fp_trap, msr_exc_en);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int lfsr;
        // R1: reset values are checked while reset is held.
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2: each flag alone, then sticky across a clean strobe.
        tag = "R2";
        drive(1, 0, 4'b0001, 0, 0, 0, 0);
        drive(1, 0, 4'b0100, 0, 0, 0, 0);
        drive(1, 0, 4'b0000, 0, 0, 0, 0);
        drive(1, 0, 4'b1010, 0, 0, 0, 0);
        idle(2);
        // R5: write with upper garbage, including bit 0, then clear.
        tag = "R5";
        drive(0, 0, 0, 1, 32'hFFFF_FFE1, 0, 0);
        idle(1);
        drive(0, 0, 0, 1, 32'h0000_0000, 0, 0);
        idle(1);
        drive(0, 0, 0, 1, 32'hA5A5_A51F, 0, 0);
        drive(0, 0, 0, 1, 32'h0, 0, 0);
        // R3: compare drops dz/ovf/unf, keeps invalid; no trap when invalid absent.
        tag = "R3";
        drive(1, 1, 4'b0111, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 0, 1, 1);
        drive(1, 1, 4'b1111, 0, 0, 1, 1);
        idle(2);
        drive(0, 0, 0, 1, 0, 1, 1);
        // R4: flags without strobe ignored.
        tag = "R4";
        drive(0, 0, 4'b1111, 0, 0, 1, 1);
        drive(0, 1, 4'b1111, 0, 0, 1, 1);
        idle(2);
        // R6: write and strobe collide.
        tag = "R6";
        drive(1, 0, 4'b0010, 1, 32'h0000_0011, 0, 0);
        idle(1);
        drive(1, 1, 4'b1001, 1, 32'h0000_0001, 0, 0);
        idle(1);
        // R7: every enable combination; back-to-back qualifying strobes.
        tag = "R7";
        drive(1, 0, 4'b0100, 0, 0, 0, 0); idle(1);
        drive(1, 0, 4'b0100, 0, 0, 1, 0); idle(1);
        drive(1, 0, 4'b0100, 0, 0, 0, 1); idle(1);
        tag = "R8";
        drive(1, 0, 4'b0100, 0, 0, 1, 1); idle(1);
        tag = "R7";
        drive(1, 0, 4'b0001, 0, 0, 1, 1);
        drive(1, 0, 4'b1000, 0, 0, 1, 1);
        drive(1, 0, 4'b0000, 0, 0, 1, 1);
        idle(2);
        // R8: cause holds after pulse ends and across a write.
        tag = "R8";
        drive(0, 0, 0, 1, 32'h1F, 1, 1);
        idle(3);
        // Mixed pseudo-random run touching R2..R8 together.
        tag = "R6";
        lfsr = 32'h1ACE;
        for (int k = 0; k < 400; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            drive(lfsr[0], lfsr[1], lfsr[5:2], lfsr[6] & lfsr[7], {lfsr[15:0], lfsr[15:0]},
                  lfsr[8] | lfsr[9], lfsr[10] | lfsr[11]);
        end
        // R1: reset mid-run clears everything.
        tag = "R1";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule